// File: doc/BRIEF.md
# Two-Wire Bus Master Transmitter with Step Status Codes

This block is a host-driven master for a two-wire open-drain bus that moves data only in the write direction. A host talks to it through three registers. The control register holds an enable, a start request, a stop request, a write-collision indicator and a step-done flag. The data register holds the next byte to send. The status register holds a one-byte code that describes the step that has just finished. The block waits for an idle bus and then creates the START condition. It shifts out the address byte with the write direction and then the data bytes, samples the acknowledge on the ninth clock, and creates repeated START and STOP conditions on request.

Every bus step ends with the step-done flag set in hardware. While the flag is high, SCL stays low, so the bus waits on the host. The host reads the status code, loads the data register if it needs to, and writes the control register with the flag bit at one to clear the flag and start the next step. SCL runs at a fixed rate: one quarter of a bit lasts `QTR_CYC` clock cycles. A data bit that the block releases high but finds low while SCL is high is reported as lost arbitration.

Top module: `i2c_mtx`

## Requirements
- R1: After reset the control read value `ctrl_o` is 0, `status_o` is 0xF8, and both `scl_oe_o` and `sda_oe_o` are 0 (lines released).
- R2: A START request (control write 0x85: bit7 flag-clear, bit2 start, bit0 enable) drives neither line while another device holds the bus. The bus counts as free only after a STOP (SDA rising while SCL is high) followed by one bit period (4·`QTR_CYC` cycles) of both lines high. The START itself is SDA falling while SCL is high.
- R3: When the START is complete, the flag (`ctrl_o` bit7) is set, `status_o` is 0x08 and SCL is held low.
- R4: Clearing the flag after a START (control write 0x81) sends the data register MSB first as the address byte. After the ninth clock the flag is set with status 0x18 if the receiver acknowledged (SDA low) and 0x20 if it did not.
- R5: Clearing the flag after an address or data step sends the data register as a data byte, with status 0x28 on acknowledge and 0x30 on no acknowledge.
- R6: While the flag is high, SCL stays low and no further SCL rising edge occurs.
- R7: A data register write while the flag is low is ignored and sets the write-collision bit (`ctrl_o` bit3). The bit stays set until a data register write made while the flag is high.
- R8: A stop request (control write 0x83, bit1 stop) produces SDA rising while SCL is high. The stop bit then clears by itself, the flag stays low, status is 0xF8 and both lines are released.
- R9: A start request made while the flag is high after a byte (control write 0x85) produces a repeated START with status 0x10. The next byte is treated as an address (0x18/0x20).
- R10: If SDA reads low while SCL is high during a bit that the block sends as 1, the block releases both lines, sets the flag and reports 0x38.
- R11: A control write that sets both stop and start (0x87) performs the STOP first and does not set the flag for it. It then creates a new START once the bus is free, reporting 0x08.
- R12: Each control write with the flag bit at one sets status to 0xF8 until the next step completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Write target: 0 control, 1 data |
| reg_wdata_i | input | 8 | Write data |
| ctrl_o | output | 8 | Control read: {flag, 0, 0, 0, wcol, start, stop, enable} |
| status_o | output | 8 | Status code of the last step |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
The main coincidence is a single control write that requests stop and start together. The STOP sequence and the start request are then both pending, and the stop completion and the start qualification meet in the same idle cycle of the engine. The bench provokes this after an acknowledged address. It judges the result on the bus and at the registers. The STOP must be seen first, with the flag still low. A new START must follow no sooner than one bit period later. The flag must rise only with status 0x08.

// File: rtl/i2c_mtx_pkg.sv
package i2c_mtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_FREE,
    ST_START,
    ST_HOLD,
    ST_BIT,
    ST_RSTART,
    ST_STOP
  } eng_state_e;

  localparam logic [7:0] SC_START    = 8'h08;
  localparam logic [7:0] SC_RSTART   = 8'h10;
  localparam logic [7:0] SC_AD_ACK   = 8'h18;
  localparam logic [7:0] SC_AD_NACK  = 8'h20;
  localparam logic [7:0] SC_DT_ACK   = 8'h28;
  localparam logic [7:0] SC_DT_NACK  = 8'h30;
  localparam logic [7:0] SC_ARB_LOST = 8'h38;
  localparam logic [7:0] SC_NONE     = 8'hF8;

  localparam int CB_EN   = 0;
  localparam int CB_STO  = 1;
  localparam int CB_STA  = 2;
  localparam int CB_WCOL = 3;
  localparam int CB_FLAG = 7;

endpackage

// File: rtl/i2c_mtx_tick.sv
module i2c_mtx_tick #(
  parameter int QTR_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == CW'(QTR_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/i2c_mtx_busmon.sv
module i2c_mtx_busmon #(
  parameter int BIT_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic bus_free_o
);
  localparam int CW = $clog2(BIT_CYC + 1);

  logic          scl_q, sda_q;
  logic          busy_q, stop_pend_q;
  logic [CW-1:0] idle_cnt_q;
  logic          start_det, stop_det, idle_done;

  assign start_det  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det   = scl_i & scl_q & ~sda_q & sda_i;
  assign idle_done  = stop_pend_q & scl_i & sda_i & (idle_cnt_q == CW'(BIT_CYC - 1));
  assign bus_free_o = ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q       <= 1'b1;
      sda_q       <= 1'b1;
      busy_q      <= 1'b0;
      stop_pend_q <= 1'b0;
      idle_cnt_q  <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_det) begin
        busy_q      <= 1'b1;
        stop_pend_q <= 1'b0;
        idle_cnt_q  <= '0;
      end else if (stop_det) begin
        stop_pend_q <= busy_q;
        idle_cnt_q  <= '0;
      end else if (idle_done) begin
        busy_q      <= 1'b0;
        stop_pend_q <= 1'b0;
        idle_cnt_q  <= '0;
      end else if (stop_pend_q) begin
        if (scl_i && sda_i) idle_cnt_q <= idle_cnt_q + 1'b1;
        else                idle_cnt_q <= '0;
      end
    end
  end

  // bus becomes free only with both lines high
  p_free_needs_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_free_o) |-> $past(scl_i && sda_i));

endmodule

// File: rtl/i2c_mtx_regs.sv
module i2c_mtx_regs
  import i2c_mtx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic       reg_sel_i,
  input  logic [7:0] reg_wdata_i,
  input  logic       set_flag_i,
  input  logic [7:0] code_i,
  input  logic       stop_done_i,
  output logic       flag_o,
  output logic       en_o,
  output logic       sta_o,
  output logic       sto_o,
  output logic       wcol_o,
  output logic [7:0] data_o,
  output logic [7:0] status_o
);
  logic       flag_q, en_q, sta_q, sto_q, wcol_q;
  logic [7:0] data_q, status_q;
  logic       ctrl_we, data_we;

  assign ctrl_we = reg_we_i & ~reg_sel_i;
  assign data_we = reg_we_i & reg_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= 1'b0;
      en_q     <= 1'b0;
      sta_q    <= 1'b0;
      sto_q    <= 1'b0;
      wcol_q   <= 1'b0;
      data_q   <= '0;
      status_q <= SC_NONE;
    end else begin
      if (ctrl_we) begin
        en_q  <= reg_wdata_i[CB_EN];
        sta_q <= reg_wdata_i[CB_STA];
        sto_q <= reg_wdata_i[CB_STO];
        if (reg_wdata_i[CB_FLAG]) begin
          flag_q   <= 1'b0;
          status_q <= SC_NONE;
        end
      end
      if (data_we) begin
        if (flag_q) begin
          data_q <= reg_wdata_i;
          wcol_q <= 1'b0;
        end else begin
          wcol_q <= 1'b1;
        end
      end
      if (set_flag_i) begin
        flag_q   <= 1'b1;
        status_q <= code_i;
      end
      if (stop_done_i) sto_q <= 1'b0;
    end
  end

  assign flag_o   = flag_q;
  assign en_o     = en_q;
  assign sta_o    = sta_q;
  assign sto_o    = sto_q;
  assign wcol_o   = wcol_q;
  assign data_o   = data_q;
  assign status_o = status_q;

  p_wcol_busy_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we && !flag_q) |=> (wcol_q && $stable(data_q)));

  p_flag_code_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> (status_q == SC_START || status_q == SC_RSTART ||
                       status_q == SC_AD_ACK || status_q == SC_AD_NACK ||
                       status_q == SC_DT_ACK || status_q == SC_DT_NACK ||
                       status_q == SC_ARB_LOST));

  p_stop_no_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_done_i |=> (!flag_q && !sto_q));

endmodule

// File: rtl/i2c_mtx_engine.sv
module i2c_mtx_engine
  import i2c_mtx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       bus_free_i,
  input  logic       sda_i,
  input  logic       en_i,
  input  logic       sta_i,
  input  logic       sto_i,
  input  logic       flag_i,
  input  logic [7:0] data_i,
  output logic       scl_low_o,
  output logic       sda_low_o,
  output logic       set_flag_o,
  output logic [7:0] code_o,
  output logic       stop_done_o
);
  eng_state_e state_q, state_d;
  logic [1:0] q_q, q_d;
  logic [3:0] bi_q, bi_d;
  logic [7:0] sh_q, sh_d;
  logic       addr_q, addr_d;
  logic       ack_q, ack_d;
  logic       scl_q, scl_d;
  logic       sda_q, sda_d;
  logic       last_bit;

  assign last_bit = (bi_q == 4'd8);

  always_comb begin
    state_d     = state_q;
    q_d         = q_q;
    bi_d        = bi_q;
    sh_d        = sh_q;
    addr_d      = addr_q;
    ack_d       = ack_q;
    scl_d       = scl_q;
    sda_d       = sda_q;
    set_flag_o  = 1'b0;
    code_o      = SC_NONE;
    stop_done_o = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
      scl_d   = 1'b0;
      sda_d   = 1'b0;
      q_d     = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!flag_i && sta_i) state_d = ST_WAIT_FREE;
        end
        ST_WAIT_FREE: begin
          if (!sta_i) state_d = ST_IDLE;
          else if (bus_free_i && tick_i) begin
            state_d = ST_START;
            q_d     = '0;
          end
        end
        ST_START: if (tick_i) begin
          q_d = q_q + 2'd1;
          if (q_q == 2'd0) sda_d = 1'b1;
          else if (q_q == 2'd2) begin
            scl_d      = 1'b1;
            state_d    = ST_HOLD;
            addr_d     = 1'b1;
            set_flag_o = 1'b1;
            code_o     = SC_START;
          end
        end
        ST_HOLD: begin
          if (!flag_i) begin
            q_d = '0;
            if (sto_i)      state_d = ST_STOP;
            else if (sta_i) state_d = ST_RSTART;
            else begin
              state_d = ST_BIT;
              bi_d    = '0;
              sh_d    = data_i;
            end
          end
        end
        ST_BIT: if (tick_i) begin
          q_d = q_q + 2'd1;
          unique case (q_q)
            2'd0: sda_d = last_bit ? 1'b0 : ~sh_q[7];
            2'd1: scl_d = 1'b0;
            2'd2: begin
              if (last_bit) ack_d = ~sda_i;
              else if (sh_q[7] && !sda_i) begin
                // released high but line low: another master won
                scl_d      = 1'b0;
                sda_d      = 1'b0;
                state_d    = ST_IDLE;
                set_flag_o = 1'b1;
                code_o     = SC_ARB_LOST;
              end
            end
            2'd3: begin
              scl_d = 1'b1;
              if (last_bit) begin
                state_d    = ST_HOLD;
                addr_d     = 1'b0;
                set_flag_o = 1'b1;
                if (addr_q) code_o = ack_q ? SC_AD_ACK : SC_AD_NACK;
                else        code_o = ack_q ? SC_DT_ACK : SC_DT_NACK;
              end else begin
                bi_d = bi_q + 4'd1;
                sh_d = {sh_q[6:0], 1'b0};
              end
            end
            default: ;
          endcase
        end
        ST_RSTART: if (tick_i) begin
          q_d = q_q + 2'd1;
          unique case (q_q)
            2'd0: sda_d = 1'b0;
            2'd1: scl_d = 1'b0;
            2'd2: sda_d = 1'b1;
            2'd3: begin
              scl_d      = 1'b1;
              state_d    = ST_HOLD;
              addr_d     = 1'b1;
              set_flag_o = 1'b1;
              code_o     = SC_RSTART;
            end
            default: ;
          endcase
        end
        ST_STOP: if (tick_i) begin
          q_d = q_q + 2'd1;
          unique case (q_q)
            2'd0: sda_d = 1'b1;
            2'd1: scl_d = 1'b0;
            2'd2: sda_d = 1'b0;
            2'd3: begin
              state_d     = ST_IDLE;
              stop_done_o = 1'b1;
            end
            default: ;
          endcase
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      q_q     <= '0;
      bi_q    <= '0;
      sh_q    <= '0;
      addr_q  <= 1'b0;
      ack_q   <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      q_q     <= q_d;
      bi_q    <= bi_d;
      sh_q    <= sh_d;
      addr_q  <= addr_d;
      ack_q   <= ack_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
    end
  end

  assign scl_low_o = scl_q;
  assign sda_low_o = sda_q;

  p_hold_scl_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> scl_q);

  p_start_on_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && q_q == 2'd0) |-> bus_free_i);

  p_sda_moves_scl_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BIT && !$stable(sda_q)) |-> scl_q);

endmodule

// File: rtl/i2c_mtx.sv
module i2c_mtx
  import i2c_mtx_pkg::*;
#(
  parameter int QTR_CYC = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic       reg_sel_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] status_o,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  localparam int BIT_CYC = 4 * QTR_CYC;

  logic       tick, bus_free;
  logic       flag, en, sta, sto, wcol;
  logic [7:0] data, code;
  logic       set_flag, stop_done;

  i2c_mtx_tick #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  i2c_mtx_busmon #(.BIT_CYC(BIT_CYC)) u_busmon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .bus_free_o (bus_free)
  );

  i2c_mtx_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .set_flag_i  (set_flag),
    .code_i      (code),
    .stop_done_i (stop_done),
    .flag_o      (flag),
    .en_o        (en),
    .sta_o       (sta),
    .sto_o       (sto),
    .wcol_o      (wcol),
    .data_o      (data),
    .status_o    (status_o)
  );

  i2c_mtx_engine u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .bus_free_i  (bus_free),
    .sda_i       (sda_i),
    .en_i        (en),
    .sta_i       (sta),
    .sto_i       (sto),
    .flag_i      (flag),
    .data_i      (data),
    .scl_low_o   (scl_oe_o),
    .sda_low_o   (sda_oe_o),
    .set_flag_o  (set_flag),
    .code_o      (code),
    .stop_done_o (stop_done)
  );

  assign ctrl_o = {flag, 3'b000, wcol, sta, sto, en};

  p_arb_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag && status_o == SC_ARB_LOST) |-> (!scl_oe_o && !sda_oe_o));

endmodule

// File: tb/test_i2c_mtx.sv
module test_i2c_mtx;
  localparam int QTR = 5;
  localparam int BITP = 4 * QTR;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] ctrl_o, status_o;
  logic       scl_oe, sda_oe;
  logic       slv_sda_low = 1'b0;
  logic       slv_ack = 1'b1;
  logic       ext_sda_low = 1'b0;
  logic       ext_scl_low = 1'b0;
  logic       scl, sda;

  assign scl = ~(scl_oe | ext_scl_low);
  assign sda = ~(sda_oe | slv_sda_low | ext_sda_low);

  i2c_mtx #(.QTR_CYC(QTR)) i_i2c_mtx (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we),
    .reg_sel_i   (reg_sel),
    .reg_wdata_i (reg_wdata),
    .ctrl_o      (ctrl_o),
    .status_o    (status_o),
    .scl_i       (scl),
    .sda_i       (sda),
    .scl_oe_o    (scl_oe),
    .sda_oe_o    (sda_oe)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // receiver model: one process owns all its state
  int         start_cnt = 0, stop_cnt = 0, rise_cnt = 0, bitcnt = 0;
  logic       acking = 1'b0;
  logic       scl_p = 1'b1, sda_p = 1'b1;
  logic [7:0] rxb = '0, rx_last = '0;
  always @(scl, sda) begin
    if (scl === 1'b1 && scl_p === 1'b1 && sda_p === 1'b1 && sda === 1'b0) begin
      start_cnt++; bitcnt = 0; acking = 1'b0; slv_sda_low = 1'b0;
    end else if (scl === 1'b1 && scl_p === 1'b1 && sda_p === 1'b0 && sda === 1'b1) begin
      stop_cnt++; bitcnt = 0; acking = 1'b0; slv_sda_low = 1'b0;
    end else if (scl_p === 1'b0 && scl === 1'b1) begin
      rise_cnt++;
      if (bitcnt < 8) begin rxb = {rxb[6:0], sda}; bitcnt++; end
    end else if (scl_p === 1'b1 && scl === 1'b0) begin
      if (acking) begin
        slv_sda_low = 1'b0; acking = 1'b0; bitcnt = 0; rx_last = rxb;
      end else if (bitcnt == 8) begin
        slv_sda_low = slv_ack; acking = 1'b1;
      end
    end
    scl_p = scl;
    sda_p = sda;
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    int n = 0;
    while (!ctrl_o[7] && n < 8000) begin @(negedge clk); n++; end
    if (n >= 8000) check(1'b0, {req, " flag timeout"}, 0, 1);
  endtask

  task automatic do_stop(input string req);
    int s0 = stop_cnt;
    int n = 0;
    wr(1'b0, 8'h83);
    while (ctrl_o[1] && n < 8000) begin @(negedge clk); n++; end
    check(stop_cnt == s0 + 1, {req, " stop seen on bus"}, stop_cnt - s0, 1);
    check(ctrl_o[7] == 1'b0 && ctrl_o[1] == 1'b0, {req, " flag low, stop bit cleared"}, ctrl_o, 8'h01);
    check(status_o == 8'hF8 && !scl_oe && !sda_oe, {req, " idle status, lines released"}, status_o, 8'hF8);
  endtask

  task automatic begin_xfer(input logic [7:0] addr, input logic ack, input logic [7:0] exp_code);
    wr(1'b0, 8'h85);
    wait_flag("R3");
    check(status_o == 8'h08, "R3 start code", status_o, 8'h08);
    wr(1'b1, addr);
    slv_ack = ack;
    wr(1'b0, 8'h81);
    wait_flag("R4");
    check(status_o == exp_code, "R4 address code", status_o, exp_code);
  endtask

  task automatic t_reset;
    check(ctrl_o == 8'h00, "R1 ctrl after reset", ctrl_o, 0);
    check(status_o == 8'hF8, "R1 status after reset", status_o, 8'hF8);
    check(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_basic;
    int s0 = start_cnt;
    int r0;
    wr(1'b0, 8'h85);
    wait_flag("R3");
    check(start_cnt == s0 + 1, "R2 start condition on bus", start_cnt - s0, 1);
    check(status_o == 8'h08, "R3 start code", status_o, 8'h08);
    check(scl_oe == 1'b1, "R3 scl held low", scl_oe, 1);
    wr(1'b1, 8'hA4);
    check(ctrl_o[3] == 1'b0, "R7 no collision with flag high", ctrl_o[3], 0);
    slv_ack = 1'b1;
    wr(1'b0, 8'h81);
    check(status_o == 8'hF8 && !ctrl_o[7], "R12 status idle after clear", status_o, 8'hF8);
    wait_flag("R4");
    check(rx_last == 8'hA4, "R4 address bits MSB first", rx_last, 8'hA4);
    check(status_o == 8'h18, "R4 address ack code", status_o, 8'h18);
    r0 = rise_cnt;
    repeat (150) @(negedge clk);
    check(rise_cnt == r0 && scl_oe && ctrl_o[7], "R6 bus stalled while flag high", rise_cnt - r0, 0);
    wr(1'b1, 8'h3C);
    slv_ack = 1'b0;
    wr(1'b0, 8'h81);
    wait_flag("R5");
    check(rx_last == 8'h3C, "R5 data byte", rx_last, 8'h3C);
    check(status_o == 8'h30, "R5 data nack code", status_o, 8'h30);
    wr(1'b1, 8'h55);
    slv_ack = 1'b1;
    wr(1'b0, 8'h81);
    wait_flag("R5");
    check(rx_last == 8'h55, "R5 second data byte", rx_last, 8'h55);
    check(status_o == 8'h28, "R5 data ack code", status_o, 8'h28);
    do_stop("R8");
  endtask

  task automatic t_rstart;
    int s0;
    begin_xfer(8'h90, 1'b0, 8'h20);
    s0 = start_cnt;
    wr(1'b0, 8'h85);
    wait_flag("R9");
    check(status_o == 8'h10, "R9 repeated start code", status_o, 8'h10);
    check(start_cnt == s0 + 1, "R9 repeated start on bus", start_cnt - s0, 1);
    wr(1'b1, 8'h92);
    slv_ack = 1'b1;
    wr(1'b0, 8'h81);
    wait_flag("R9");
    check(status_o == 8'h18 && rx_last == 8'h92, "R9 address after repeated start", status_o, 8'h18);
    do_stop("R8");
  endtask

  task automatic t_wcol;
    wr(1'b0, 8'h85);
    wait_flag("R3");
    wr(1'b1, 8'h6A);
    slv_ack = 1'b1;
    wr(1'b0, 8'h81);
    wr(1'b1, 8'hEE);
    check(ctrl_o[3] == 1'b1, "R7 collision bit set", ctrl_o[3], 1);
    wait_flag("R7");
    check(rx_last == 8'h6A, "R7 busy write ignored", rx_last, 8'h6A);
    check(ctrl_o[3] == 1'b1, "R7 collision bit sticky", ctrl_o[3], 1);
    wr(1'b1, 8'h12);
    check(ctrl_o[3] == 1'b0, "R7 collision cleared by valid write", ctrl_o[3], 0);
    wr(1'b0, 8'h81);
    wait_flag("R5");
    check(rx_last == 8'h12 && status_o == 8'h28, "R7 valid write sent", rx_last, 8'h12);
    do_stop("R8");
  endtask

  task automatic t_busy_wait;
    int t0;
    ext_sda_low = 1'b1;
    repeat (10) @(negedge clk);
    ext_scl_low = 1'b1;
    repeat (10) @(negedge clk);
    wr(1'b0, 8'h85);
    repeat (200) @(negedge clk);
    check(!scl_oe && !sda_oe && !ctrl_o[7], "R2 no drive while bus busy", {scl_oe, sda_oe}, 0);
    ext_scl_low = 1'b0;
    repeat (10) @(negedge clk);
    ext_sda_low = 1'b0;
    t0 = cyc;
    wait_flag("R2");
    check(cyc - t0 >= BITP, "R2 start only after idle bit period", cyc - t0, BITP);
    check(status_o == 8'h08, "R3 start code after wait", status_o, 8'h08);
    wr(1'b1, 8'hA0);
    slv_ack = 1'b1;
    wr(1'b0, 8'h81);
    wait_flag("R4");
    check(status_o == 8'h18, "R4 address ack code", status_o, 8'h18);
    do_stop("R8");
  endtask

  task automatic t_arb;
    wr(1'b0, 8'h85);
    wait_flag("R3");
    wr(1'b1, 8'hFF);
    ext_sda_low = 1'b1;
    wr(1'b0, 8'h81);
    wait_flag("R10");
    check(status_o == 8'h38, "R10 arbitration lost code", status_o, 8'h38);
    check(!scl_oe && !sda_oe, "R10 both lines released", {scl_oe, sda_oe}, 0);
    repeat (10) @(negedge clk);
    ext_sda_low = 1'b0;
    wr(1'b0, 8'h81);
    check(status_o == 8'hF8 && !ctrl_o[7], "R12 status idle after clear", status_o, 8'hF8);
    repeat (3 * BITP) @(negedge clk);
  endtask

  task automatic t_stop_start;
    int s0, st0, t_stop;
    int n = 0;
    logic flag_at_stop = 1'b0;
    begin_xfer(8'hC8, 1'b1, 8'h18);
    s0 = stop_cnt;
    st0 = start_cnt;
    t_stop = 0;
    wr(1'b0, 8'h87);
    while (!ctrl_o[7] && n < 8000) begin
      @(negedge clk); n++;
      if (t_stop == 0 && stop_cnt != s0) begin t_stop = cyc; flag_at_stop = ctrl_o[7]; end
    end
    check(stop_cnt == s0 + 1 && t_stop != 0, "R11 stop performed first", stop_cnt - s0, 1);
    check(flag_at_stop == 1'b0, "R11 no flag for the stop", flag_at_stop, 0);
    check(start_cnt == st0 + 1 && cyc - t_stop >= BITP, "R11 new start after free bus", cyc - t_stop, BITP);
    check(status_o == 8'h08, "R11 start code after chained stop", status_o, 8'h08);
    do_stop("R8");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_rstart();
    t_wcol();
    t_busy_wait();
    t_arb();
    t_stop_start();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule